// File: doc/BRIEF.md
# Serial Channel Register File

This block holds the four software-visible registers of one asynchronous serial channel and sits between a bus-side register decoder and a UART core. The decoder supplies a two-bit register select, read and write strobes and 16-bit write data; the block answers with combinational read data. The UART core reports each completed character with its data byte and parity and stop-bit error flags. The block offers a one-byte transmit buffer to the core through a ready/load handshake.

Each register has a bit layout that software relies on. The receiver status register shows a full flag and an interrupt enable, and it has a write-only trigger bit that emits a one-clock reader-run pulse. The receiver data register returns the byte together with sticky parity, framing and overrun bits and their summary bit. These error bits are not cleared by reading. Each one clears when a later character arrives without that fault. The transmitter status register shows buffer-empty, an interrupt enable and a break control that holds the line in space. The block also watches for a received break, meaning an all-zero character with a bad stop bit. Depending on a mode input, it turns that break into a one-clock halt request or a one-clock reboot request.

Top module: `serchan_regs`

## Requirements
- R1: Register select codes are 0 receiver status, 1 receiver data, 2 transmitter status, 3 transmitter data. Receiver full (status bit 7) is 0 after reset. It is set at the clock edge where `rx_done` is high, and it is cleared by a read strobe on the receiver data register. Writes cannot change bit 7. When a data read and a new character fall in the same cycle, full stays set and no overrun is recorded.
- R2: Bit 6 of both status registers is a read/write interrupt enable, reset 0. `rx_irq` equals full AND enable. `tx_irq` equals empty AND enable. All unused status bits read zero.
- R3: Writing 1 to receiver status bit 0 drives `reader_pulse` high for exactly the one cycle after the write edge and clears receiver full. Bit 0 always reads 0.
- R4: Transmitter status bit 7 (empty) is 1 after reset. A write to the transmitter data register while empty stores the byte and clears empty. A write while not empty is ignored. While the buffer is occupied and `tx_ready` is high, `tx_load` is high with `tx_char` holding the stored byte, and empty is set again at that edge.
- R5: Transmitter status bit 0 is read/write, reset 0, and drives `brk_level` directly.
- R6: Receiver data bits 7:0 hold the last character. When `cfg_seven_bit` is 1, bit 7 is stored as 0.
- R7: Receiver data bit 12 (parity error) takes the parity flag of each new character. It reads 0 while `cfg_parity_en` is 0.
- R8: Receiver data bit 13 (framing error) takes the stop-bit error flag of each new character, so it holds until a character with a good stop bit arrives.
- R9: Receiver data bit 14 (overrun) is set by a character arriving while full is set and not being read. It is cleared by a character arriving when full was clear. Bit 15 is the OR of bits 14:12. Bits 11:8 read 0.
- R10: When `BRK_ENABLE` is 1, an all-zero character with a stop error produces a one-cycle `halt_req` if `cfg_brk_mode` is 1, or a one-cycle `reboot_req` if it is 2, in the cycle after the character edge. Any other character or mode produces neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| rd_stb | input | 1 | Read strobe (side effects only) |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| cfg_seven_bit | input | 1 | Seven-bit character mode |
| cfg_parity_en | input | 1 | Parity checking enabled |
| cfg_brk_mode | input | 2 | Break action: 0 none, 1 halt, 2 reboot, 3 none |
| rx_done | input | 1 | UART character complete |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Parity mismatch on this character |
| rx_stop_err | input | 1 | Invalid first stop bit on this character |
| tx_ready | input | 1 | UART transmitter can accept a byte |
| tx_load | output | 1 | Byte handed to the transmitter this cycle |
| tx_char | output | 8 | Byte to transmit |
| rx_full | output | 1 | Receiver full flag |
| rx_ie | output | 1 | Receiver interrupt enable |
| tx_empty | output | 1 | Transmit buffer empty flag |
| tx_ie | output | 1 | Transmitter interrupt enable |
| rx_irq | output | 1 | Receiver interrupt request |
| tx_irq | output | 1 | Transmitter interrupt request |
| brk_level | output | 1 | Hold line in space |
| reader_pulse | output | 1 | One-clock reader-run pulse |
| halt_req | output | 1 | Break-triggered halt request |
| reboot_req | output | 1 | Break-triggered reboot request |

## Verification
Every cycle, the assertions check the causal rules. Full rises only after a character, and a data read clears full. Overrun rises only when full was already set. The reader pulse follows a trigger write. A load always empties the buffer, and the buffered byte stays steady while it waits. The break level follows the last status write. Halt and reboot never coincide, and each comes only after a character with a stop error. The exact bit layout of each register under mixed error histories can only be shown by the bench's scenarios, which cover the character vector table, seven-bit masking, disabled parity, the same-cycle read and arrival, an ignored write to a full buffer, and the break actions.

// File: rtl/serchan_pkg.sv
package serchan_pkg;
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CTL0_BIT = 0;
    localparam int PE_BIT   = 12;
    localparam int FE_BIT   = 13;
    localparam int OVR_BIT  = 14;
    localparam int EF_BIT   = 15;

    typedef enum logic [1:0] {
        SEL_RX_CTL = 2'd0,
        SEL_RX_DAT = 2'd1,
        SEL_TX_CTL = 2'd2,
        SEL_TX_DAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        BRK_NONE   = 2'd0,
        BRK_HALT   = 2'd1,
        BRK_REBOOT = 2'd2,
        BRK_NONE_B = 2'd3
    } brk_mode_e;
endpackage

// File: rtl/serchan_rx.sv
module serchan_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              wr_ie,
    input  logic              wr_trig,
    input  logic              dat_rd,
    input  logic              cfg_seven_bit,
    input  logic              cfg_parity_en,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_par_err,
    input  logic              rx_stop_err,
    output logic              rx_full,
    output logic              rx_ie,
    output logic              reader_pulse,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_ovr
);
    typedef struct packed {
        logic              full;
        logic              ie;
        logic              pulse;
        logic [DATA_W-1:0] data;
        logic              pe;
        logic              fe;
        logic              ovr;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic [DATA_W-1:0] keep_mask;
    logic              trig_now;

    always_comb begin
        keep_mask = '1;
        if (cfg_seven_bit) keep_mask[DATA_W-1] = 1'b0;
        trig_now = ctl_wr && wr_trig;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (ctl_wr) st_d.ie = wr_ie;
        if (trig_now) begin
            st_d.pulse = 1'b1;
            st_d.full  = 1'b0;
        end
        if (dat_rd) st_d.full = 1'b0;
        if (rx_done) begin
            st_d.full = 1'b1;
            st_d.ovr  = st_q.full && !dat_rd && !trig_now;
            st_d.pe   = rx_par_err;
            st_d.fe   = rx_stop_err;
            st_d.data = rx_char & keep_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_full      = st_q.full;
    assign rx_ie        = st_q.ie;
    assign reader_pulse = st_q.pulse;
    assign rx_data      = st_q.data;
    assign err_par      = st_q.pe && cfg_parity_en;
    assign err_frm      = st_q.fe;
    assign err_ovr      = st_q.ovr;

    a_r1_full_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_done));
    a_r1_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !rx_done) |=> !rx_full);
    a_r3_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        reader_pulse |-> $past(ctl_wr && wr_trig));
    a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(rx_full));
endmodule

// File: rtl/serchan_tx.sv
module serchan_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              wr_ie,
    input  logic              wr_brk,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              tx_ready,
    output logic              tx_empty,
    output logic              tx_ie,
    output logic              brk_level,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_char
);
    typedef struct packed {
        logic              occ;
        logic              ie;
        logic              brk;
        logic [DATA_W-1:0] hold;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      load_now;

    always_comb begin
        load_now = st_q.occ && tx_ready;
        st_d     = st_q;
        if (ctl_wr) begin
            st_d.ie  = wr_ie;
            st_d.brk = wr_brk;
        end
        if (load_now) st_d.occ = 1'b0;
        if (dat_wr && !st_q.occ) begin
            st_d.occ  = 1'b1;
            st_d.hold = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_empty  = !st_q.occ;
    assign tx_ie     = st_q.ie;
    assign brk_level = st_q.brk;
    assign tx_load   = load_now;
    assign tx_char   = st_q.hold;

    a_r4_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> tx_empty);
    a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && tx_empty) |=> !tx_empty);
    a_r4_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && !$past(tx_empty)) |-> $stable(tx_char));
    a_r5_brk_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr) |-> (brk_level == $past(wr_brk)));
endmodule

// File: rtl/serchan_brk.sv
module serchan_brk
    import serchan_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit BRK_ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_stop_err,
    input  logic [1:0]        cfg_brk_mode,
    output logic              halt_req,
    output logic              reboot_req
);
    generate
        if (BRK_ENABLE) begin : g_brk
            typedef struct packed {
                logic halt;
                logic reboot;
            } brk_state_t;

            brk_state_t st_d, st_q;
            logic       is_break;

            always_comb begin
                is_break  = rx_done && rx_stop_err && (rx_char == '0);
                st_d      = '0;
                if (is_break) begin
                    st_d.halt   = (cfg_brk_mode == BRK_HALT);
                    st_d.reboot = (cfg_brk_mode == BRK_REBOOT);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign halt_req   = st_q.halt;
            assign reboot_req = st_q.reboot;
        end else begin : g_nobrk
            logic unused_brk_in;
            assign unused_brk_in = ^{clk, rst_n, rx_done, rx_char, rx_stop_err, cfg_brk_mode};
            assign halt_req   = 1'b0;
            assign reboot_req = 1'b0;
        end
    endgenerate

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_req && reboot_req));
    a_r10_needs_break: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req || reboot_req) |-> $past(rx_done && rx_stop_err));
endmodule

// File: rtl/serchan_regs.sv
module serchan_regs
    import serchan_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int REG_W      = 16,
    parameter bit BRK_ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cfg_seven_bit,
    input  logic              cfg_parity_en,
    input  logic [1:0]        cfg_brk_mode,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_par_err,
    input  logic              rx_stop_err,
    input  logic              tx_ready,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_char,
    output logic              rx_full,
    output logic              rx_ie,
    output logic              tx_empty,
    output logic              tx_ie,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              brk_level,
    output logic              reader_pulse,
    output logic              halt_req,
    output logic              reboot_req
);
    logic              rx_ctl_wr, rx_dat_rd, tx_ctl_wr, tx_dat_wr;
    logic [DATA_W-1:0] rx_data;
    logic              err_par, err_frm, err_ovr;
    logic              unused_wr_bits;

    assign rx_ctl_wr      = wr_stb && (reg_sel == SEL_RX_CTL);
    assign rx_dat_rd      = rd_stb && (reg_sel == SEL_RX_DAT);
    assign tx_ctl_wr      = wr_stb && (reg_sel == SEL_TX_CTL);
    assign tx_dat_wr      = wr_stb && (reg_sel == SEL_TX_DAT);
    assign unused_wr_bits = ^wr_data;

    serchan_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(rx_ctl_wr), .wr_ie(wr_data[IE_BIT]), .wr_trig(wr_data[CTL0_BIT]),
        .dat_rd(rx_dat_rd),
        .cfg_seven_bit(cfg_seven_bit), .cfg_parity_en(cfg_parity_en),
        .rx_done(rx_done), .rx_char(rx_char),
        .rx_par_err(rx_par_err), .rx_stop_err(rx_stop_err),
        .rx_full(rx_full), .rx_ie(rx_ie), .reader_pulse(reader_pulse),
        .rx_data(rx_data), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr)
    );

    serchan_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(tx_ctl_wr), .wr_ie(wr_data[IE_BIT]), .wr_brk(wr_data[CTL0_BIT]),
        .dat_wr(tx_dat_wr), .wr_byte(wr_data[DATA_W-1:0]),
        .tx_ready(tx_ready),
        .tx_empty(tx_empty), .tx_ie(tx_ie), .brk_level(brk_level),
        .tx_load(tx_load), .tx_char(tx_char)
    );

    serchan_brk #(.DATA_W(DATA_W), .BRK_ENABLE(BRK_ENABLE)) u_brk (
        .clk(clk), .rst_n(rst_n),
        .rx_done(rx_done), .rx_char(rx_char), .rx_stop_err(rx_stop_err),
        .cfg_brk_mode(cfg_brk_mode),
        .halt_req(halt_req), .reboot_req(reboot_req)
    );

    assign rx_irq = rx_full && rx_ie;
    assign tx_irq = tx_empty && tx_ie;

    always_comb begin
        rd_data = '0;
        case (reg_sel)
            SEL_RX_CTL: begin
                rd_data[FLAG_BIT] = rx_full;
                rd_data[IE_BIT]   = rx_ie;
            end
            SEL_RX_DAT: begin
                rd_data[DATA_W-1:0] = rx_data;
                rd_data[PE_BIT]     = err_par;
                rd_data[FE_BIT]     = err_frm;
                rd_data[OVR_BIT]    = err_ovr;
                rd_data[EF_BIT]     = err_par || err_frm || err_ovr;
            end
            SEL_TX_CTL: begin
                rd_data[FLAG_BIT] = tx_empty;
                rd_data[IE_BIT]   = tx_ie;
                rd_data[CTL0_BIT] = brk_level;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: tb/serchan_regs_bench.sv
`timescale 1ns/100ps
module serchan_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cfg_seven_bit = 1'b0, cfg_parity_en = 1'b1;
    logic [1:0]  cfg_brk_mode = 2'd0;
    logic        rx_done = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_par_err = 1'b0, rx_stop_err = 1'b0, tx_ready = 1'b0;
    logic        tx_load, rx_full, rx_ie, tx_empty, tx_ie, rx_irq, tx_irq;
    logic        brk_level, reader_pulse, halt_req, reboot_req;
    logic [7:0]  tx_char;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    serchan_regs u_serchan_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .cfg_seven_bit(cfg_seven_bit),
        .cfg_parity_en(cfg_parity_en), .cfg_brk_mode(cfg_brk_mode), .rx_done(rx_done),
        .rx_char(rx_char), .rx_par_err(rx_par_err), .rx_stop_err(rx_stop_err),
        .tx_ready(tx_ready), .tx_load(tx_load), .tx_char(tx_char), .rx_full(rx_full),
        .rx_ie(rx_ie), .tx_empty(tx_empty), .tx_ie(tx_ie), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .brk_level(brk_level), .reader_pulse(reader_pulse), .halt_req(halt_req),
        .reboot_req(reboot_req)
    );

    typedef struct packed {
        logic [7:0]  ch;
        logic        pe;
        logic        se;
        logic        consume;
        logic [15:0] exp;
    } vec_t;

    // R6 R7 R8 R9: character history walked with parity on, 8-bit mode
    localparam vec_t VECS [8] = '{
        '{8'h41, 1'b0, 1'b0, 1'b1, 16'h0041},
        '{8'h55, 1'b1, 1'b0, 1'b0, 16'h9055},
        '{8'h3C, 1'b0, 1'b0, 1'b1, 16'hC03C},
        '{8'h7E, 1'b0, 1'b1, 1'b1, 16'hA07E},
        '{8'h00, 1'b0, 1'b1, 1'b1, 16'hA000},
        '{8'hFF, 1'b1, 1'b1, 1'b0, 16'hB0FF},
        '{8'h12, 1'b0, 1'b0, 1'b1, 16'hC012},
        '{8'h80, 1'b0, 1'b0, 1'b1, 16'h0080}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] c, input logic pe, input logic se);
        @(negedge clk);
        rx_done = 1'b1; rx_char = c; rx_par_err = pe; rx_stop_err = se;
        @(negedge clk);
        rx_done = 1'b0; rx_par_err = 1'b0; rx_stop_err = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, input string tag, input logic [15:0] exp);
        reg_sel = sel;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic consume();
        @(negedge clk);
        reg_sel = 2'd1; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R2, R4, R5)
        peek(2'd0, "R1 reset rx status", 16'h0000);
        peek(2'd1, "R6 reset rx data", 16'h0000);
        peek(2'd2, "R4 reset tx status", 16'h0080);
        chk("R5 reset break level", brk_level, 0);

        foreach (VECS[i]) begin
            send_char(VECS[i].ch, VECS[i].pe, VECS[i].se);
            peek(2'd1, $sformatf("R9 vector %0d rx data", i), VECS[i].exp);
            if (VECS[i].consume) consume();
        end
        peek(2'd0, "R1 full clear after table", 16'h0000);

        // R1: bit 7 is read-only
        reg_wr(2'd0, 16'h0080);
        peek(2'd0, "R1 write to full bit ignored", 16'h0000);

        // R2: receiver interrupt enable and request
        reg_wr(2'd0, 16'hFF40 & 16'hFFFE);
        peek(2'd0, "R2 rx enable readback", 16'h0040);
        chk("R2 rx irq idle", rx_irq, 0);
        send_char(8'h33, 1'b0, 1'b0);
        peek(2'd0, "R2 rx status full+ie", 16'h00C0);
        chk("R2 rx irq raised", rx_irq, 1);
        consume();
        chk("R2 rx irq after read", rx_irq, 0);

        // R3: reader pulse
        send_char(8'h21, 1'b0, 1'b0);
        reg_wr(2'd0, 16'h0041);
        chk("R3 reader pulse high", reader_pulse, 1);
        peek(2'd0, "R3 full cleared, bit0 reads 0", 16'h0040);
        @(negedge clk);
        chk("R3 reader pulse one clock", reader_pulse, 0);

        // R1: read and new character in the same cycle
        send_char(8'h10, 1'b0, 1'b0);
        @(negedge clk);
        reg_sel = 2'd1; rd_stb = 1'b1; rx_done = 1'b1; rx_char = 8'h20;
        @(negedge clk);
        rd_stb = 1'b0; rx_done = 1'b0;
        chk("R1 same-cycle read keeps full", rx_full, 1);
        peek(2'd1, "R1 same-cycle read no overrun", 16'h0020);
        consume();

        // R5, R2: transmitter status
        reg_wr(2'd2, 16'hFFFF);
        peek(2'd2, "R5 tx status with break", 16'h00C1);
        chk("R5 break level set", brk_level, 1);
        chk("R2 tx irq", tx_irq, 1);
        reg_wr(2'd2, 16'h0000);
        peek(2'd2, "R5 break cleared", 16'h0080);
        chk("R5 break level low", brk_level, 0);

        // R4: buffer handshake
        tx_ready = 1'b0;
        reg_wr(2'd3, 16'h00A5);
        peek(2'd2, "R4 empty cleared", 16'h0000);
        chk("R4 no load while not ready", tx_load, 0);
        reg_wr(2'd3, 16'h005A);
        chk("R4 write while full ignored", tx_char, 8'hA5);
        @(negedge clk);
        tx_ready = 1'b1;
        #0.5;
        chk("R4 load strobe", tx_load, 1);
        chk("R4 load byte", tx_char, 8'hA5);
        @(negedge clk);
        chk("R4 empty after load", tx_empty, 1);
        chk("R4 load ends", tx_load, 0);
        tx_ready = 1'b0;

        // R6: seven-bit mode
        cfg_seven_bit = 1'b1;
        send_char(8'hC3, 1'b0, 1'b0);
        peek(2'd1, "R6 seven-bit mask", 16'h0043);
        consume();
        cfg_seven_bit = 1'b0;

        // R7: parity disabled
        cfg_parity_en = 1'b0;
        send_char(8'h11, 1'b1, 1'b0);
        peek(2'd1, "R7 parity off reads zero", 16'h0011);
        consume();
        cfg_parity_en = 1'b1;

        // R10: break actions
        cfg_brk_mode = 2'd1;
        send_char(8'h00, 1'b0, 1'b1);
        chk("R10 halt request", halt_req, 1);
        chk("R10 no reboot in halt mode", reboot_req, 0);
        @(negedge clk);
        chk("R10 halt one clock", halt_req, 0);
        consume();
        cfg_brk_mode = 2'd2;
        send_char(8'h00, 1'b0, 1'b1);
        chk("R10 reboot request", reboot_req, 1);
        chk("R10 no halt in reboot mode", halt_req, 0);
        consume();
        cfg_brk_mode = 2'd1;
        send_char(8'h01, 1'b0, 1'b1);
        chk("R10 nonzero char no halt", halt_req, 0);
        consume();
        cfg_brk_mode = 2'd0;
        send_char(8'h00, 1'b0, 1'b1);
        chk("R10 mode none no halt", halt_req, 0);
        chk("R10 mode none no reboot", reboot_req, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule